// File: doc/BRIEF.md
# Serial-Programmed Multi-Channel DAC Code Register Controller

This block is a two-wire serial bus target that keeps a bank of 10-bit converter codes and one write-disable flag. It drives the codes and the flag on parallel outputs. A host first sends a one-byte register pointer. It then either writes code words as two-byte pairs, high byte first, or restarts the bus in the read direction and reads the pairs back. After each pair the pointer moves on, so a single transaction can sweep a run of registers.

SCL and SDA are sampled with two-flop synchronizers on a fast system clock. The bus is driven only through an open-drain enable, `sda_oe`: when it is high the line is pulled low. The controller is one enumerated state machine with these states:

- `ST_IDLE`: the bus is free.
- `ST_DEV`: shifting in the device address byte.
- `ST_DEV_ACK`: the address acknowledge slot.
- `ST_PTR`: shifting in the pointer byte.
- `ST_PTR_ACK`: the pointer acknowledge slot.
- `ST_WDATA`: shifting in a write data byte.
- `ST_WDATA_ACK`: the data acknowledge slot.
- `ST_RDATA`: shifting out a read data byte.
- `ST_RDATA_ACK`: sampling the host's acknowledge.
- `ST_IGNORE`: sitting out the rest of a rejected or ended transfer.

The transitions are:

- Any state goes to `ST_DEV` on a START and to `ST_IDLE` on a STOP.
- `ST_DEV` goes to `ST_DEV_ACK` on an address match, otherwise to `ST_IGNORE`.
- `ST_DEV_ACK` goes to `ST_RDATA` when the direction bit is 1, otherwise to `ST_PTR`.
- `ST_PTR` goes to `ST_PTR_ACK` for a valid pointer, otherwise to `ST_IGNORE`.
- `ST_PTR_ACK` goes to `ST_WDATA`.
- `ST_WDATA` and `ST_WDATA_ACK` alternate for as long as the host keeps writing.
- `ST_RDATA` goes to `ST_RDATA_ACK`.
- `ST_RDATA_ACK` goes back to `ST_RDATA` when the host acknowledges, and to `ST_IGNORE` when it does not.

Top module: `i2cdac_ctrl`

## Requirements
- R1: A device byte whose upper seven bits equal the address parameter (default 0x4C, so 0x98 to write and 0x99 to read) is acknowledged. Any other device byte is not acknowledged, and the rest of that transfer is ignored.
- R2: A pointer byte is acknowledged only if bits 7:5 are zero and bits 4:0 are at most 20. Any other pointer byte is not acknowledged and changes no register.
- R3: A written code is built from bits 1:0 of the first (high) byte as code bits 9:8 and the whole second (low) byte as code bits 7:0. The other high-byte bits are ignored, apart from the pattern checked in R6.
- R4: A register changes only when the low byte of its pair has been received. A STOP or START that follows a lone high byte leaves the register unchanged.
- R5: In a write, the pointer moves to the next register after every complete pair, so consecutive pairs fill consecutive registers.
- R6: A pair whose high byte has bits 7:6 equal to 01 writes nothing. The pointer still moves on after it.
- R7: Register 20 holds the write-disable flag in bit 0 of the low byte. Only the first pair after a pointer byte of 20 writes it. A burst write stops at register 19: later pairs in that transfer are acknowledged and dropped, and the flag is left unchanged.
- R8: While the write-disable flag is 1, pairs aimed at registers 0 to 19 are acknowledged and ignored. Register 20 stays writable.
- R9: A read returns two bytes per register, high byte first. Bits 7:2 of the high byte read as zero. Register 20 returns the flag in bit 0 of the low byte, and every other bit of it reads as zero.
- R10: In a read, the pointer moves on (holding at 20) after each low byte that the host acknowledges. A host not-acknowledge ends the read with SDA released.
- R11: Every write data byte is acknowledged.
- R12: After reset all codes and the flag are zero and SDA is released. The controller changes `sda_oe` only while SCL is low, except at START or STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe | output | 1 | Pull SDA low when 1 (open-drain enable) |
| dac_codes | output | NUM_DAC*CODE_W (200) | All code registers, register k at bits k*10+9 : k*10 |
| wr_lock | output | 1 | Write-disable flag |

## Verification
The bench builds the controller with its defaults: 20 code registers of 10 bits and device address 0x4C. With that configuration it can sweep every 5-bit pointer value and the high-bit variants, and fill and read back the full bank in single bursts. Expected codes come from an arithmetic pattern. The same configuration puts the saturation point at 19 and the flag at 20 within a few pairs of each other. This lets one short burst test the drop behaviour, the reserved high-byte pattern and the locking flag, with the bank's contents checked after each step.

// File: rtl/i2cdac_pkg.sv
package i2cdac_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_DEV_ACK,
        ST_PTR,
        ST_PTR_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RDATA_ACK,
        ST_IGNORE
    } tgt_state_e;

endpackage

// File: rtl/i2cdac_linesync.sv
module i2cdac_linesync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_hi,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES:0] scl_pipe;
    logic [STAGES:0] sda_pipe;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-1:0], scl_in};
            sda_pipe <= {sda_pipe[STAGES-1:0], sda_in};
        end
    end

    assign scl_hi    = scl_pipe[STAGES-1];
    assign sda_s     = sda_pipe[STAGES-1];
    assign scl_rise  = scl_pipe[STAGES-1] & ~scl_pipe[STAGES];
    assign scl_fall  = ~scl_pipe[STAGES-1] & scl_pipe[STAGES];
    assign start_det = scl_pipe[STAGES-1] & scl_pipe[STAGES] & sda_pipe[STAGES] & ~sda_pipe[STAGES-1];
    assign stop_det  = scl_pipe[STAGES-1] & scl_pipe[STAGES] & ~sda_pipe[STAGES] & sda_pipe[STAGES-1];

endmodule

// File: rtl/i2cdac_regbank.sv
module i2cdac_regbank #(
    parameter int NUM_DAC = 20,
    parameter int CODE_W  = 10,
    parameter int PW      = 5
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      code_we,
    input  logic [PW-1:0]             code_idx,
    input  logic [CODE_W-1:0]         code_wdata,
    input  logic                      lock_we,
    input  logic                      lock_wdata,
    input  logic [PW-1:0]             rd_idx,
    output logic [NUM_DAC*CODE_W-1:0] codes_flat,
    output logic                      lock_q,
    output logic [7:0]                rd_msb,
    output logic [7:0]                rd_lsb
);
    localparam logic [PW-1:0] LOCK_P = PW'(NUM_DAC);

    logic [CODE_W-1:0] codes_q [NUM_DAC];
    logic [15:0]       rd_word;

    for (genvar g = 0; g < NUM_DAC; g++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                codes_q[g] <= '0;
            else if (code_we && code_idx == PW'(g))
                codes_q[g] <= code_wdata;
        end
        assign codes_flat[g*CODE_W +: CODE_W] = codes_q[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            lock_q <= 1'b0;
        else if (lock_we)
            lock_q <= lock_wdata;
    end

    always_comb begin
        if (rd_idx < LOCK_P)
            rd_word = {{(16-CODE_W){1'b0}}, codes_q[rd_idx]};
        else
            rd_word = {15'd0, lock_q};
    end
    assign rd_msb = rd_word[15:8];
    assign rd_lsb = rd_word[7:0];

    // R4
    codes_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(codes_flat) |-> $past(code_we));

    // R8
    lock_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(lock_q) |-> $stable(codes_flat));

endmodule

// File: rtl/i2cdac_ctrl.sv
module i2cdac_ctrl
    import i2cdac_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h4C,
    parameter int         NUM_DAC  = 20,
    parameter int         CODE_W   = 10
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      scl_i,
    input  logic                      sda_i,
    output logic                      sda_oe,
    output logic [NUM_DAC*CODE_W-1:0] dac_codes,
    output logic                      wr_lock
);
    localparam int            PW     = $clog2(NUM_DAC + 1);
    localparam logic [PW-1:0] LOCK_P = PW'(NUM_DAC);
    localparam logic [PW-1:0] LAST_P = PW'(NUM_DAC - 1);

    tgt_state_e state_q, state_d;

    logic          scl_hi, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic [3:0]    bit_cnt;
    logic [7:0]    shreg, tx_q, msb_q;
    logic [PW-1:0] ptr_q;
    logic          half_q, drop_q, rw_q, host_ack_q;
    logic          byte_done, dev_hit, ptr_ok, pair_end, pair_ok;
    logic          code_we, lock_we;
    logic [7:0]    rd_msb, rd_lsb;

    i2cdac_linesync #(.STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_i), .sda_in(sda_i),
        .scl_hi(scl_hi), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    assign byte_done = scl_fall && (bit_cnt == 4'd8);
    assign dev_hit   = (shreg[7:1] == DEV_ADDR);
    assign ptr_ok    = (shreg[7:PW] == '0) && (shreg[PW-1:0] <= LOCK_P);
    assign pair_end  = (state_q == ST_WDATA) && byte_done && half_q;
    assign pair_ok   = (msb_q[7:6] != 2'b01) && !drop_q;
    assign code_we   = pair_end && pair_ok && (ptr_q != LOCK_P) && !wr_lock;
    assign lock_we   = pair_end && pair_ok && (ptr_q == LOCK_P);

    i2cdac_regbank #(.NUM_DAC(NUM_DAC), .CODE_W(CODE_W), .PW(PW)) u_bank (
        .clk(clk), .rst_n(rst_n),
        .code_we(code_we), .code_idx(ptr_q), .code_wdata(CODE_W'({msb_q, shreg})),
        .lock_we(lock_we), .lock_wdata(shreg[0]),
        .rd_idx(ptr_q), .codes_flat(dac_codes), .lock_q(wr_lock),
        .rd_msb(rd_msb), .rd_lsb(rd_lsb)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (stop_det)
            state_d = ST_IDLE;
        else if (start_det)
            state_d = ST_DEV;
        else begin
            unique case (state_q)
                ST_IDLE, ST_IGNORE: state_d = state_q;
                ST_DEV:       if (byte_done) state_d = dev_hit ? ST_DEV_ACK : ST_IGNORE;
                ST_DEV_ACK:   if (scl_fall)  state_d = rw_q ? ST_RDATA : ST_PTR;
                ST_PTR:       if (byte_done) state_d = ptr_ok ? ST_PTR_ACK : ST_IGNORE;
                ST_PTR_ACK:   if (scl_fall)  state_d = ST_WDATA;
                ST_WDATA:     if (byte_done) state_d = ST_WDATA_ACK;
                ST_WDATA_ACK: if (scl_fall)  state_d = ST_WDATA;
                ST_RDATA:     if (scl_fall && bit_cnt == 4'd7) state_d = ST_RDATA_ACK;
                ST_RDATA_ACK: if (scl_fall)  state_d = host_ack_q ? ST_RDATA : ST_IGNORE;
                default:      state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt    <= '0;
            shreg      <= '0;
            tx_q       <= '0;
            msb_q      <= '0;
            ptr_q      <= '0;
            half_q     <= 1'b0;
            drop_q     <= 1'b0;
            rw_q       <= 1'b0;
            host_ack_q <= 1'b0;
            sda_oe     <= 1'b0;
        end else if (start_det || stop_det) begin
            bit_cnt <= '0;
            half_q  <= 1'b0;
            sda_oe  <= 1'b0;
        end else begin
            if (scl_rise && (state_q == ST_DEV || state_q == ST_PTR || state_q == ST_WDATA)) begin
                shreg   <= {shreg[6:0], sda_s};
                bit_cnt <= bit_cnt + 4'd1;
            end
            unique case (state_q)
                ST_DEV: if (byte_done) begin
                    bit_cnt <= '0;
                    rw_q    <= shreg[0];
                    sda_oe  <= dev_hit;
                end
                ST_DEV_ACK: if (scl_fall) begin
                    bit_cnt <= '0;
                    half_q  <= 1'b0;
                    sda_oe  <= rw_q && !rd_msb[7];
                    tx_q    <= {rd_msb[6:0], 1'b0};
                end
                ST_PTR: if (byte_done) begin
                    bit_cnt <= '0;
                    sda_oe  <= ptr_ok;
                    if (ptr_ok) begin
                        ptr_q  <= shreg[PW-1:0];
                        drop_q <= 1'b0;
                        half_q <= 1'b0;
                    end
                end
                ST_PTR_ACK, ST_WDATA_ACK: if (scl_fall) sda_oe <= 1'b0;
                ST_WDATA: if (byte_done) begin
                    bit_cnt <= '0;
                    sda_oe  <= 1'b1;
                    if (!half_q) begin
                        msb_q  <= shreg;
                        half_q <= 1'b1;
                    end else begin
                        half_q <= 1'b0;
                        if (ptr_q >= LAST_P) drop_q <= 1'b1;
                        else                 ptr_q  <= ptr_q + 1'b1;
                    end
                end
                ST_RDATA: if (scl_fall) begin
                    if (bit_cnt == 4'd7) begin
                        bit_cnt <= '0;
                        sda_oe  <= 1'b0;
                    end else begin
                        bit_cnt <= bit_cnt + 4'd1;
                        sda_oe  <= !tx_q[7];
                        tx_q    <= {tx_q[6:0], 1'b0};
                    end
                end
                ST_RDATA_ACK: begin
                    if (scl_rise) begin
                        host_ack_q <= !sda_s;
                        if (half_q && !sda_s && ptr_q < LOCK_P) ptr_q <= ptr_q + 1'b1;
                    end
                    if (scl_fall && host_ack_q) begin
                        half_q <= !half_q;
                        sda_oe <= half_q ? !rd_msb[7] : !rd_lsb[7];
                        tx_q   <= half_q ? {rd_msb[6:0], 1'b0} : {rd_lsb[6:0], 1'b0};
                    end
                end
                default: ;
            endcase
        end
    end

    // R12
    sda_quiet_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_hi && $past(scl_hi) && !$past(start_det) && !$past(stop_det)) |-> $stable(sda_oe));

    // R2
    ptr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_q <= LOCK_P);

    // R10
    released_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE || state_q == ST_IGNORE) |-> !sda_oe);

    // R7
    lock_only_at_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_lock != $past(wr_lock)) |-> $past(ptr_q == LOCK_P));

endmodule

// File: tb/sim_i2cdac_ctrl.sv
module sim_i2cdac_ctrl;
    localparam int NDAC = 20;
    localparam int HALF = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_drv = 1'b1;
    logic sda_drv = 1'b1;
    logic sda_oe, wr_lock;
    logic [NDAC*10-1:0] dac_codes;
    wire  sda_line = sda_drv & ~sda_oe;

    int errors = 0;
    int checks = 0;
    bit done = 0;
    int exp_code [NDAC];
    int exp_lock = 0;
    logic [15:0] pay [32];
    logic [15:0] got [32];

    always #5 clk = ~clk;

    i2cdac_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_drv), .sda_i(sda_line),
        .sda_oe(sda_oe), .dac_codes(dac_codes), .wr_lock(wr_lock)
    );

    task automatic check(input string tag, input int act, input int expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, expv);
        end
    endtask

    task automatic hold();
        repeat (HALF) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_drv = 1'b1; hold();
        scl_drv = 1'b1; hold();
        sda_drv = 1'b0; hold();
        scl_drv = 1'b0; hold();
    endtask

    task automatic bus_stop();
        sda_drv = 1'b0; hold();
        scl_drv = 1'b1; hold();
        sda_drv = 1'b1; hold();
    endtask

    task automatic send_bit(input logic b);
        sda_drv = b; hold();
        scl_drv = 1'b1; hold();
        scl_drv = 1'b0; hold();
    endtask

    task automatic recv_bit(output logic b);
        sda_drv = 1'b1; hold();
        scl_drv = 1'b1; hold();
        b = sda_line;
        scl_drv = 1'b0; hold();
    endtask

    task automatic put_byte(input logic [7:0] v, output logic acked);
        logic bv;
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
        recv_bit(bv);
        acked = !bv;
    endtask

    task automatic get_byte(input logic ack, output logic [7:0] v);
        logic bv;
        for (int i = 7; i >= 0; i--) begin
            recv_bit(bv);
            v[i] = bv;
        end
        send_bit(!ack);
    endtask

    // write pointer p then n pairs from pay[]; every ack must be seen (R11)
    task automatic wr_burst(input logic [7:0] p, input int n);
        logic a;
        bus_start();
        put_byte(8'h98, a); check("R1 write address ack", int'(a), 1);
        put_byte(p, a);     check("R2 pointer ack", int'(a), 1);
        for (int k = 0; k < n; k++) begin
            put_byte(pay[k][15:8], a); check("R11 msb ack", int'(a), 1);
            put_byte(pay[k][7:0], a);  check("R11 lsb ack", int'(a), 1);
        end
        bus_stop();
    endtask

    // read n pairs from pointer p; last byte not acknowledged
    task automatic rd_burst(input logic [7:0] p, input int n, input bit via_stop);
        logic a;
        logic [7:0] hb, lb;
        bus_start();
        put_byte(8'h98, a);
        put_byte(p, a);
        if (via_stop) bus_stop();
        bus_start();
        put_byte(8'h99, a); check("R1 read address ack", int'(a), 1);
        for (int k = 0; k < n; k++) begin
            get_byte(1'b1, hb);
            get_byte(k != n - 1, lb);
            got[k] = {hb, lb};
        end
        check("R10 sda released after nack", int'(sda_oe), 0);
        bus_stop();
    endtask

    task automatic check_bank(input string tag);
        for (int i = 0; i < NDAC; i++)
            check(tag, int'(dac_codes[i*10 +: 10]), exp_code[i]);
        check(tag, int'(wr_lock), exp_lock);
    endtask

    initial begin
        logic a;
        int v;
        for (int i = 0; i < NDAC; i++) exp_code[i] = 0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        hold();

        // R12 reset state
        check_bank("R12 reset");
        check("R12 sda released", int'(sda_oe), 0);

        // R1 wrong address
        bus_start();
        put_byte(8'h9A, a); check("R1 wrong address nack", int'(a), 0);
        put_byte(8'h03, a); check("R1 ignored after nack", int'(a), 0);
        bus_stop();
        check_bank("R1 no change");

        // R3 single writes, high bits of msb ignored
        pay[0] = 16'h02A5; wr_burst(8'd3, 1); exp_code[3] = 'h2A5;
        pay[0] = 16'hFD11; wr_burst(8'd9, 1); exp_code[9] = 'h111;
        check_bank("R3 single write");

        // R5 full burst sweep
        for (int i = 0; i < NDAC; i++) begin
            v = (i * 173 + 29) & 'h3FF;
            pay[i] = 16'(v);
            exp_code[i] = v;
        end
        wr_burst(8'd0, NDAC);
        check_bank("R5 burst fill");

        // R2 pointer sweep
        for (int p = 0; p < 40; p++) begin
            logic [7:0] pb;
            pb = (p < 32) ? 8'(p) : 8'((p - 32) * 32 + 3);
            bus_start();
            put_byte(8'h98, a);
            put_byte(pb, a);
            check("R2 pointer accept", int'(a), int'(pb <= 8'd20));
            bus_stop();
        end
        check_bank("R2 no change");

        // R4 lone msb then STOP, then lone msb then START
        bus_start(); put_byte(8'h98, a); put_byte(8'd5, a); put_byte(8'h03, a); bus_stop();
        bus_start(); put_byte(8'h98, a); put_byte(8'd5, a); put_byte(8'h01, a);
        bus_start(); put_byte(8'h9A, a); bus_stop();
        check_bank("R4 partial pair");

        // R6 reserved msb pattern
        pay[0] = 16'h4100; pay[1] = 16'h0233;
        wr_burst(8'd6, 2); exp_code[7] = 'h233;
        check_bank("R6 reserved msb");

        // R7 burst saturates at 19, flag untouched
        pay[0] = 16'h0101; pay[1] = 16'h0202; pay[2] = 16'h0303; pay[3] = 16'h0001;
        wr_burst(8'd18, 4); exp_code[18] = 'h101; exp_code[19] = 'h202;
        check_bank("R7 saturate from 18");
        pay[0] = 16'h0001; pay[1] = 16'h0001;
        wr_burst(8'd19, 2); exp_code[19] = 1;
        check_bank("R7 saturate from 19");

        // R7 flag by single write; second pair dropped
        pay[0] = 16'h0001; pay[1] = 16'h0000;
        wr_burst(8'd20, 2); exp_lock = 1;
        check_bank("R7 flag set");

        // R8 locked writes ignored but acked
        pay[0] = 16'h03FF; wr_burst(8'd2, 1);
        for (int i = 0; i < 4; i++) pay[i] = 16'h0155;
        wr_burst(8'd0, 4);
        check_bank("R8 locked");

        // R9 read flag at 20 through burst from 19
        rd_burst(8'd19, 3, 1'b0);
        check("R9 reg19", int'(got[0]), exp_code[19]);
        check("R9 reg20 flag", int'(got[1]), 1);
        check("R10 hold at 20", int'(got[2]), 1);

        pay[0] = 16'h0000; wr_burst(8'd20, 1); exp_lock = 0;
        pay[0] = 16'h03FF; wr_burst(8'd2, 1);  exp_code[2] = 'h3FF;
        check_bank("R8 unlocked");

        // R9 R10 full readback sweep with repeated START
        rd_burst(8'd0, NDAC + 1, 1'b0);
        for (int i = 0; i < NDAC; i++) check("R9 readback", int'(got[i]), exp_code[i]);
        check("R9 reg20 clear", int'(got[NDAC]), 0);

        // R10 read via STOP/START, short burst
        rd_burst(8'd4, 3, 1'b1);
        for (int i = 0; i < 3; i++) check("R10 short read", int'(got[i]), exp_code[4 + i]);

        // R10 nack on the high byte ends the read
        bus_start(); put_byte(8'h98, a); put_byte(8'd2, a);
        bus_start(); put_byte(8'h99, a);
        begin
            logic [7:0] hb;
            get_byte(1'b0, hb);
            check("R10 msb before nack", int'(hb), exp_code[2] >> 8);
            check("R10 release on nack", int'(sda_oe), 0);
        end
        bus_stop();
        check_bank("R10 bank intact");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule